// File: doc/BRIEF.md
# Octal Low-Side Switch Protection Controller

This block is the digital control core of an eight-channel low-side power switch. Every channel takes its on command from one of two places: a parallel input pin, or a bit of an on/off register that the serial interface loads. The block merges that command with two digital status flags per channel, overtemperature and current-limit-active. From them it produces a gate enable for each channel, a sticky fault bit for each channel and one shared active-low fault output that a microcontroller can use as an interrupt.

Faults latch the affected channel off. The latch clears only when the channel's active command source shows a fresh low-to-high edge. The overload reaction is programmable. In report mode a long current limit only records a fault. In shutdown mode a longer current limit also switches the channel off. The analog sensing and the serial frame decoding sit outside this block; the register values arrive here as parallel words.

Top module: `oct_sw_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, every gate enable is 0 and the on/off register and all fault bits clear. The configuration reset values are: source select 8'h0F (channels 0..3 parallel), report overload mode, and input-4 target 3. After release, parallel-driven channels follow their pins.
- R2: With `pol_high`=1 a parallel pin at 1 means on. With `pol_high`=0 a pin at 0 means on. This applies to all four pins.
- R3: Pins 0..2 drive channels 0..2. Pin 3 is ORed into the parallel command of the channel numbered by the 3-bit target field (value 3 means channel 3).
- R4: When `src_sel[i]`=1, channel i uses its parallel command. When it is 0, the channel uses bit i of the on/off register. A rising edge with `onoff_wr`=1 loads `onoff_data` into that register.
- R5: If channel i is commanded on and its overtemperature flag is high at an edge, the channel latches off from the next cycle and its fault bit sets.
- R6: The overtemperature flag of a channel that is commanded off has no effect.
- R7: An overtemperature or overload latch clears only at an edge where the channel's command is 1 and was 0 at the previous edge. A set condition at that same edge wins. Until then the gate stays 0 even with the command held on.
- R8: In report mode (`ovl_mode`=0), a current-limit flag high on a commanded channel for FILT_CNT consecutive edges sets the fault bit and leaves the gate on.
- R9: In shutdown mode (`ovl_mode`=1), the flag high for OFF_CNT consecutive edges sets the fault bit and latches the channel off.
- R10: A current-limit run that drops for one edge, or whose channel goes uncommanded, restarts the count from zero.
- R11: Fault bits are sticky. A `flt_clr` edge clears them, and a set at the same edge wins.
- R12: `fault_n` is 0 exactly when at least one fault bit is 1.
- R13: Source select, overload mode and input-4 target are sampled at the rising edge and take effect in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset / sleep |
| par_in | input | 4 | Parallel command pins |
| pol_high | input | 1 | 1: pins active high, 0: pins active low |
| src_sel | input | 8 | Per-channel source, 1 = parallel pin |
| ovl_mode | input | 1 | 0 report only, 1 report and shut down |
| in4_tgt | input | 3 | Channel index driven by pin 3 |
| onoff_wr | input | 1 | Load strobe for the on/off register |
| onoff_data | input | 8 | On/off register value |
| ot_flag | input | 8 | Overtemperature status per channel |
| ilim_flag | input | 8 | Current-limit-active status per channel |
| flt_clr | input | 1 | Fault register clear strobe |
| gate_en | output | 8 | Per-channel gate enable |
| fault_reg | output | 8 | Sticky fault bits |
| fault_n | output | 1 | Shared fault output, active low |

## Verification
The assertions assume that every status flag and pin is already synchronous to `clk` and changes only between edges. The stimulus meets this by driving all inputs at the falling edge. The latch-hold properties also assume that a channel's command changes only through its pin, its source select or a register load, so any release is an observable rising command edge. The random stimulus holds current-limit flags in long runs and keeps overtemperature pulses rare. This lets both the filter and the shutdown thresholds be crossed and also interrupted.

// File: rtl/oct_sw_pkg.sv
package oct_sw_pkg;

    localparam int NCH   = 8;
    localparam int NPAR  = 4;
    localparam int TGT_W = $clog2(NCH);

    typedef enum logic {
        OVL_REPORT   = 1'b0,
        OVL_SHUTDOWN = 1'b1
    } ovl_mode_e;

    typedef struct packed {
        logic [NCH-1:0]   src_par;
        ovl_mode_e        mode;
        logic [TGT_W-1:0] in4_tgt;
    } cfg_t;

    localparam logic [NCH-1:0]   SRC_RST = NCH'((1 << NPAR) - 1);
    localparam logic [TGT_W-1:0] TGT_RST = TGT_W'(NPAR - 1);

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/oct_sw_cmd.sv
module oct_sw_cmd
    import oct_sw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAR-1:0]  par_in,
    input  logic             pol_high,
    input  logic [NCH-1:0]   src_sel,
    input  logic             ovl_mode,
    input  logic [TGT_W-1:0] in4_tgt,
    input  logic             onoff_wr,
    input  logic [NCH-1:0]   onoff_data,
    output ovl_mode_e        mode_q,
    output logic [NCH-1:0]   cmd
);

    cfg_t           cfg_q;
    logic [NCH-1:0] onoff_q;
    logic [NPAR-1:0] pin_act;
    logic [NCH-1:0] par_cmd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.src_par <= SRC_RST;
            cfg_q.mode    <= OVL_REPORT;
            cfg_q.in4_tgt <= TGT_RST;
            onoff_q       <= '0;
        end else begin
            cfg_q.src_par <= src_sel;
            cfg_q.mode    <= ovl_mode_e'(ovl_mode);
            cfg_q.in4_tgt <= in4_tgt;
            if (onoff_wr) onoff_q <= onoff_data;
        end
    end

    always_comb begin
        pin_act = pol_high ? par_in : ~par_in;
        par_cmd = '0;
        for (int i = 0; i < NPAR - 1; i++) par_cmd[i] = pin_act[i];
        par_cmd[cfg_q.in4_tgt] = par_cmd[cfg_q.in4_tgt] | pin_act[NPAR-1];
        cmd = (cfg_q.src_par & par_cmd) | (~cfg_q.src_par & onoff_q);
    end

    assign mode_q = cfg_q.mode;

    AST_SLEEP_CLEARS_ONOFF: assert property (@(posedge clk) !rst_n |=> (onoff_q == '0)); // R1
    AST_SLEEP_CFG_DEFAULT: assert property (@(posedge clk)
        !rst_n |=> (cfg_q.src_par == SRC_RST && cfg_q.in4_tgt == TGT_RST && cfg_q.mode == OVL_REPORT)); // R1

endmodule

// File: rtl/oct_sw_chan.sv
module oct_sw_chan
    import oct_sw_pkg::*;
#(
    parameter int FILT_CNT = 3,
    parameter int OFF_CNT  = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd,
    input  ovl_mode_e mode,
    input  logic      ot_flag,
    input  logic      ilim_flag,
    input  logic      flt_clr,
    output logic      gate_en,
    output logic      fault
);

    localparam int CMAX = max_of(FILT_CNT, OFF_CNT);
    localparam int CW   = $clog2(CMAX + 1);

    logic          cmd_prev;
    logic          ot_lat;
    logic          ol_lat;
    logic [CW-1:0] cnt;
    logic [CW-1:0] thr;
    logic          rise, ilim_on, ot_set, hit, ol_set;

    always_comb begin
        rise    = cmd & ~cmd_prev;
        ilim_on = cmd & ilim_flag;
        ot_set  = cmd & ot_flag;
        thr     = (mode == OVL_SHUTDOWN) ? CW'(OFF_CNT - 1) : CW'(FILT_CNT - 1);
        hit     = ilim_on && (cnt == thr);
        ol_set  = hit && (mode == OVL_SHUTDOWN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_prev <= 1'b0;
            ot_lat   <= 1'b0;
            ol_lat   <= 1'b0;
            cnt      <= '0;
            fault    <= 1'b0;
        end else begin
            cmd_prev <= cmd;
            if (!ilim_on)                 cnt <= '0;
            else if (cnt != CW'(CMAX))    cnt <= cnt + 1'b1;
            if (ot_set)      ot_lat <= 1'b1;
            else if (rise)   ot_lat <= 1'b0;
            if (ol_set)      ol_lat <= 1'b1;
            else if (rise)   ol_lat <= 1'b0;
            if (ot_set || hit) fault <= 1'b1;
            else if (flt_clr)  fault <= 1'b0;
        end
    end

    assign gate_en = rst_n & cmd & ~ot_lat & ~ol_lat;

    AST_OT_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_lat && !rise) |=> ot_lat); // R7
    AST_OL_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ol_lat && !rise) |=> ol_lat); // R7
    AST_OT_IGNORED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd && !ot_lat) |=> !ot_lat); // R6
    AST_REPORT_NO_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OVL_REPORT && !ol_lat) |=> !ol_lat); // R8
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !flt_clr) |=> fault); // R11
    AST_OL_SETS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!ol_lat && !flt_clr) |=> (!ol_lat || fault)); // R9

endmodule

// File: rtl/oct_sw_ctrl.sv
module oct_sw_ctrl
    import oct_sw_pkg::*;
#(
    parameter int FILT_CNT = 3,
    parameter int OFF_CNT  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAR-1:0]  par_in,
    input  logic             pol_high,
    input  logic [NCH-1:0]   src_sel,
    input  logic             ovl_mode,
    input  logic [TGT_W-1:0] in4_tgt,
    input  logic             onoff_wr,
    input  logic [NCH-1:0]   onoff_data,
    input  logic [NCH-1:0]   ot_flag,
    input  logic [NCH-1:0]   ilim_flag,
    input  logic             flt_clr,
    output logic [NCH-1:0]   gate_en,
    output logic [NCH-1:0]   fault_reg,
    output logic             fault_n
);

    ovl_mode_e      mode_q;
    logic [NCH-1:0] cmd;

    oct_sw_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_in     (par_in),
        .pol_high   (pol_high),
        .src_sel    (src_sel),
        .ovl_mode   (ovl_mode),
        .in4_tgt    (in4_tgt),
        .onoff_wr   (onoff_wr),
        .onoff_data (onoff_data),
        .mode_q     (mode_q),
        .cmd        (cmd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        oct_sw_chan #(
            .FILT_CNT (FILT_CNT),
            .OFF_CNT  (OFF_CNT)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd[g]),
            .mode      (mode_q),
            .ot_flag   (ot_flag[g]),
            .ilim_flag (ilim_flag[g]),
            .flt_clr   (flt_clr),
            .gate_en   (gate_en[g]),
            .fault     (fault_reg[g])
        );
    end

    assign fault_n = ~|fault_reg;

    AST_SLEEP_FAULTS_CLEAR: assert property (@(posedge clk) !rst_n |=> (fault_reg == '0 && fault_n)); // R1
    AST_SLEEP_GATES_OFF: assert property (@(posedge clk) !rst_n |-> (gate_en == '0)); // R1

endmodule

// File: tb/tb_oct_sw_ctrl.sv
module tb_oct_sw_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int FILT = 3;
    localparam int OFFD = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] par_in;
    logic       pol_high;
    logic [7:0] src_sel;
    logic       ovl_mode;
    logic [2:0] in4_tgt;
    logic       onoff_wr;
    logic [7:0] onoff_data;
    logic [7:0] ot_flag;
    logic [7:0] ilim_flag;
    logic       flt_clr;
    logic [7:0] gate_en;
    logic [7:0] fault_reg;
    logic       fault_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    logic [7:0] m_src, m_onoff, m_prev, m_ot, m_ol, m_flt;
    logic       m_mode;
    logic [2:0] m_tgt;
    int         m_cnt [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    oct_sw_ctrl #(.FILT_CNT(FILT), .OFF_CNT(OFFD)) dut (
        .clk(clk), .rst_n(rst_n), .par_in(par_in), .pol_high(pol_high),
        .src_sel(src_sel), .ovl_mode(ovl_mode), .in4_tgt(in4_tgt),
        .onoff_wr(onoff_wr), .onoff_data(onoff_data), .ot_flag(ot_flag),
        .ilim_flag(ilim_flag), .flt_clr(flt_clr), .gate_en(gate_en),
        .fault_reg(fault_reg), .fault_n(fault_n)
    );

    function automatic logic [7:0] f_cmd();
        logic [3:0] act;
        logic [7:0] pc;
        act = pol_high ? par_in : ~par_in;
        pc = '0;
        for (int i = 0; i < 3; i++) pc[i] = act[i];
        pc[m_tgt] = pc[m_tgt] | act[3];
        return (m_src & pc) | (~m_src & m_onoff);
    endfunction

    function automatic logic [7:0] f_gate();
        return rst_n ? (f_cmd() & ~m_ot & ~m_ol) : 8'h00;
    endfunction

    task automatic m_step();
        logic [7:0] c;
        c = f_cmd();
        if (!rst_n) begin
            m_src = 8'h0F; m_mode = 1'b0; m_tgt = 3'd3; m_onoff = '0;
            m_prev = '0; m_ot = '0; m_ol = '0; m_flt = '0;
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                logic rise, il, ots, hit;
                int thr;
                rise = c[i] & ~m_prev[i];
                il   = c[i] & ilim_flag[i];
                ots  = c[i] & ot_flag[i];
                thr  = m_mode ? OFFD - 1 : FILT - 1;
                hit  = il && (m_cnt[i] == thr);
                if (!il) m_cnt[i] = 0;
                else if (m_cnt[i] < OFFD) m_cnt[i] = m_cnt[i] + 1;
                if (ots) m_ot[i] = 1'b1; else if (rise) m_ot[i] = 1'b0;
                if (hit && m_mode) m_ol[i] = 1'b1; else if (rise) m_ol[i] = 1'b0;
                if (ots || hit) m_flt[i] = 1'b1; else if (flt_clr) m_flt[i] = 1'b0;
            end
            m_prev = c;
            m_src = src_sel; m_mode = ovl_mode; m_tgt = in4_tgt;
            if (onoff_wr) m_onoff = onoff_data;
        end
    endtask

    task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // compare all outputs against the reference, then advance one clock
    task automatic cyc(input string tag);
        logic [7:0] eg;
        #1;
        eg = f_gate();
        n_chk++;
        if (gate_en !== eg || fault_reg !== m_flt || fault_n !== ~|m_flt) begin
            n_bad++;
            $display("FAIL %s gate=%h/%h fault=%h/%h fault_n=%b/%b",
                     tag, gate_en, eg, fault_reg, m_flt, fault_n, ~|m_flt);
        end
        @(posedge clk);
        m_step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 0; par_in = 4'b0000; pol_high = 1; src_sel = 8'h0F; ovl_mode = 0;
        in4_tgt = 3'd3; onoff_wr = 0; onoff_data = '0; ot_flag = '0; ilim_flag = '0;
        flt_clr = 0;
        @(posedge clk); m_step();
        @(posedge clk); m_step();
        @(negedge clk);

        // R1: reset state
        par_in = 4'b0101; ot_flag = 8'h01;
        #1; check8("R1 gates off in reset", gate_en, 8'h00);
        check8("R1 faults clear", fault_reg, 8'h00);
        check8("R12 fault_n idle", {7'b0, fault_n}, 8'h01);
        cyc("R1 reset");
        ot_flag = '0;
        rst_n = 1;
        #1; check8("R1 parallel follows pins after release", gate_en, 8'h05);
        cyc("R2 release");

        // R2: polarity
        #1; check8("R2 active high", gate_en, 8'h05);
        pol_high = 0;
        #1; check8("R2 active low", gate_en, 8'h0A);
        cyc("R2 low");
        pol_high = 1;
        cyc("R2 back high");

        // R3 / R13: remap of pin 3
        par_in = 4'b1000; src_sel = 8'h4F; in4_tgt = 3'd6;
        #1; check8("R13 cfg not yet applied", gate_en, 8'h08);
        cyc("R13 sample");
        check8("R3 pin3 remapped to ch6", gate_en, 8'h40);
        cyc("R3 hold");

        // R4: on/off register source
        src_sel = 8'h0F; in4_tgt = 3'd3; par_in = 4'b0000;
        onoff_wr = 1; onoff_data = 8'hF0;
        cyc("R4 load");
        onoff_wr = 0;
        #1; check8("R4 register drives ch4..7", gate_en, 8'hF0);

        // R5 / R12: overtemperature
        ot_flag = 8'h10;
        cyc("R5 ot");
        ot_flag = '0;
        #1; check8("R5 ch4 latched off", gate_en, 8'hE0);
        check8("R5 fault bit4", fault_reg, 8'h10);
        check8("R12 fault_n low", {7'b0, fault_n}, 8'h00);
        cyc("R7 hold a");
        cyc("R7 hold b");
        #1; check8("R7 stays off while command held", gate_en, 8'hE0);
        onoff_wr = 1; onoff_data = 8'hE0;
        cyc("R7 drop");
        onoff_data = 8'hF0;
        cyc("R7 raise");
        onoff_wr = 0;
        #1; check8("R7 off until rise sampled", gate_en, 8'hE0);
        cyc("R7 clear");
        check8("R7 released after rise", gate_en, 8'hF0);

        // R11
        check8("R11 fault sticky", fault_reg, 8'h10);
        flt_clr = 1;
        cyc("R11 clr");
        flt_clr = 0;
        #1; check8("R11 cleared", fault_reg, 8'h00);
        check8("R12 fault_n high", {7'b0, fault_n}, 8'h01);

        // R6: ot ignored on an off channel
        ot_flag = 8'h01;
        cyc("R6 ot while off");
        ot_flag = '0; par_in = 4'b0001;
        #1; check8("R6 ch0 turns on", gate_en, 8'hF1);
        check8("R6 no fault", fault_reg, 8'h00);

        // R8: report mode filter
        par_in = 4'b0011; ilim_flag = 8'h02;
        cyc("R8 a"); cyc("R8 b");
        check8("R8 below filter", fault_reg, 8'h00);
        cyc("R8 c");
        check8("R8 fault after filter", fault_reg, 8'h02);
        check8("R8 channel stays on", gate_en, 8'hF3);
        ilim_flag = '0; flt_clr = 1;
        cyc("R8 clr");
        flt_clr = 0;

        // R10: restart of count
        ilim_flag = 8'h02; cyc("R10 a"); cyc("R10 b");
        ilim_flag = 8'h00; cyc("R10 gap");
        ilim_flag = 8'h02; cyc("R10 c"); cyc("R10 d");
        check8("R10 no fault after broken run", fault_reg, 8'h00);
        ilim_flag = '0; cyc("R10 end");

        // R9: shutdown mode
        ovl_mode = 1; cyc("R9 mode");
        ilim_flag = 8'h02;
        for (int k = 0; k < OFFD - 1; k++) cyc("R9 run");
        check8("R9 still on before delay", gate_en, 8'hF3);
        cyc("R9 last");
        check8("R9 channel off", gate_en, 8'hF1);
        check8("R9 fault set", fault_reg, 8'h02);
        ilim_flag = '0; par_in = 4'b0001;
        cyc("R9 cmd low");
        par_in = 4'b0011;
        #1; check8("R9 latched until rise sampled", gate_en, 8'hF1);
        cyc("R9 rise");
        check8("R9 released", gate_en, 8'hF3);
        flt_clr = 1; ovl_mode = 0; cyc("R9 clr"); flt_clr = 0;

        // random phase, all requirements against the reference
        for (int n = 0; n < 5000; n++) begin
            if ($urandom_range(0, 3) == 0) par_in = par_in ^ 4'($urandom_range(0, 15));
            if ($urandom_range(0, 40) == 0) pol_high = ~pol_high;
            if ($urandom_range(0, 60) == 0) src_sel = 8'($urandom());
            if ($urandom_range(0, 50) == 0) ovl_mode = ~ovl_mode;
            if ($urandom_range(0, 60) == 0) in4_tgt = 3'($urandom_range(0, 7));
            onoff_wr = ($urandom_range(0, 7) == 0);
            onoff_data = 8'($urandom());
            for (int c = 0; c < 8; c++) begin
                if ($urandom_range(0, 9) == 0) ilim_flag[c] = ~ilim_flag[c];
                ot_flag[c] = ($urandom_range(0, 60) == 0);
            end
            flt_clr = ($urandom_range(0, 15) == 0);
            rst_n = ($urandom_range(0, 700) != 0);
            cyc("R4 R5 R8 R9 R10 R11 R12 R13 random");
        end
        finish_run();
    end

endmodule